// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block belongs to the special-case stage of a single-precision floating-point datapath. It receives operands A and B, a 3-bit policy code and a default-NaN-mode bit. It then decides what NaN the operation returns when one or both operands are NaNs. Each operand is sorted into one of three kinds: ordinary number, quiet NaN or signaling NaN. The policy code picks one of five priority schemes for choosing which operand propagates. Any signaling NaN that is chosen leaves the block with its quiet bit set.

With default-NaN mode on, the block ignores the operands and the policy code and returns the canonical NaN 0x7FC00000. With default-NaN mode off and no usable policy configured, the block raises a rule error and does not pick an operand. The invalid-operation flag marks any signaling NaN on the inputs. All outputs are registered and appear one clock after an input strobe.

Top module: `nan_prop_sel`

## Requirements
- R1: An operand is a NaN when exponent bits [30:23] are all ones and fraction bits [22:0] are non-zero. It is quiet when bit 22 is 1 and signaling otherwise. When neither operand is a NaN, is_nan_result is 0, result is 0x00000000 and rule_error is 0.
- R2: Policy code 1 takes the first match in this order: A if signaling, B if signaling, A if quiet, otherwise B.
- R3: Policy code 2 takes the first match in this order: B if signaling, A if signaling, B if quiet, otherwise A.
- R4: Policy code 3 returns A whenever A is any NaN and B otherwise. Policy code 4 returns B whenever B is any NaN and A otherwise.
- R5: Under policy code 5, a quiet NaN wins over a signaling NaN. A lone NaN paired with a number is returned.
- R6: Under policy code 5, when both operands are NaNs of the same kind, the one with the larger fraction wins. If the fractions are equal, a positive operand wins over a negative one. If the signs are also equal, A wins.
- R7: Whenever is_nan_result is 1, result bit 22 is 1. A chosen signaling NaN keeps its sign and other fraction bits and only has bit 22 set.
- R8: With dflt_nan_mode at 1 and a NaN present, the result is 0x7FC00000 and rule_error is 0, whatever the policy code (codes 0 to 7).
- R9: With dflt_nan_mode at 0, a NaN present and policy code 0, 6 or 7, rule_error is 1 and the result is 0x7FC00000.
- R10: invalid_flag is 1 exactly when at least one operand is a signaling NaN, in every mode.
- R11: After reset all outputs are 0. out_valid is 1 in the cycle after each in_valid strobe. Without a strobe, out_valid drops to 0 and the other outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| rule_sel | input | 3 | Propagation policy code (0 to 5 defined) |
| dflt_nan_mode | input | 1 | Return the canonical NaN instead of an operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 32 | Selected and quieted NaN, canonical NaN, or zero |
| is_nan_result | output | 1 | At least one operand was a NaN |
| invalid_flag | output | 1 | A signaling NaN was present |
| rule_error | output | 1 | NaN present with no valid policy configured |

## Verification
The block holds state only in its output register. A wrong selection or a missed quieting therefore shows up on result in the very cycle after the strobe that caused it, and it does not carry over into later vectors. A wrong classification usually shows on more than one output at the same time: invalid_flag, is_nan_result and the chosen operand all come from the same operand kinds. A hold fault shows as result changing, or out_valid staying high, in the first cycle with no strobe.

// File: rtl/nan_prop_pkg.sv
// Package: shared operand-kind type and policy codes for the NaN selector.
// Assumes IEEE-style binary layout {sign, exponent, fraction}.
package nan_prop_pkg;

    typedef enum logic [1:0] {
        KIND_NUM  = 2'd0,
        KIND_QNAN = 2'd1,
        KIND_SNAN = 2'd2
    } nan_kind_e;

    localparam logic [2:0] POL_NONE   = 3'd0;
    localparam logic [2:0] POL_SIG_AB = 3'd1;
    localparam logic [2:0] POL_SIG_BA = 3'd2;
    localparam logic [2:0] POL_AB     = 3'd3;
    localparam logic [2:0] POL_BA     = 3'd4;
    localparam logic [2:0] POL_MAG    = 3'd5;

endpackage

// File: rtl/nan_classify.sv
// Module: nan_classify
// Sorts one operand into number, quiet NaN or signaling NaN.
// Assumes the quiet bit is the fraction MSB.
module nan_classify
    import nan_prop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output nan_kind_e             kind
);
    localparam int W = EXP_W + FRAC_W + 1;

    logic exp_ones;
    logic frac_nz;

    // Decode the exponent and fraction fields into a kind.
    always_comb begin
        exp_ones = &operand[W-2:FRAC_W];
        frac_nz  = |operand[FRAC_W-1:0];
        if (!(exp_ones && frac_nz))
            kind = KIND_NUM;
        else if (operand[FRAC_W-1])
            kind = KIND_QNAN;
        else
            kind = KIND_SNAN;
    end
endmodule

// File: rtl/nan_pick.sv
// Module: nan_pick
// Applies the selected priority policy to two operand kinds and says
// whether B propagates. Flags an unusable policy code.
// Assumes at least one operand is a NaN when pick_b is used.
module nan_pick
    import nan_prop_pkg::*;
#(
    parameter int FRAC_W = 23
) (
    input  nan_kind_e         kind_a,
    input  nan_kind_e         kind_b,
    input  logic              sign_a,
    input  logic              sign_b,
    input  logic [FRAC_W-1:0] frac_a,
    input  logic [FRAC_W-1:0] frac_b,
    input  logic [2:0]        policy,
    output logic              pick_b,
    output logic              policy_bad
);
    logic a_wins_mag;

    // Magnitude tie-break: larger fraction, then positive sign, then A.
    always_comb begin
        if (frac_a != frac_b)
            a_wins_mag = frac_a > frac_b;
        else
            a_wins_mag = !(sign_a && !sign_b);
    end

    // Priority decision for each policy code.
    always_comb begin
        pick_b     = 1'b0;
        policy_bad = 1'b0;
        case (policy)
            POL_SIG_AB: begin
                if (kind_a == KIND_SNAN)      pick_b = 1'b0;
                else if (kind_b == KIND_SNAN) pick_b = 1'b1;
                else if (kind_a == KIND_QNAN) pick_b = 1'b0;
                else                          pick_b = 1'b1;
            end
            POL_SIG_BA: begin
                if (kind_b == KIND_SNAN)      pick_b = 1'b1;
                else if (kind_a == KIND_SNAN) pick_b = 1'b0;
                else if (kind_b == KIND_QNAN) pick_b = 1'b1;
                else                          pick_b = 1'b0;
            end
            POL_AB: pick_b = (kind_a == KIND_NUM);
            POL_BA: pick_b = (kind_b != KIND_NUM);
            POL_MAG: begin
                if (kind_a == KIND_NUM)       pick_b = 1'b1;
                else if (kind_b == KIND_NUM)  pick_b = 1'b0;
                else if (kind_a != kind_b)    pick_b = (kind_b == KIND_QNAN);
                else                          pick_b = !a_wins_mag;
            end
            default: policy_bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/nan_prop_sel.sv
// Module: nan_prop_sel (top)
// Special-case NaN stage: classifies both operands, picks the propagated
// NaN under a run-time policy, quiets it, and registers the outcome.
// Assumes in_valid is a single-cycle strobe per operation.
module nan_prop_sel
    import nan_prop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [EXP_W+FRAC_W:0]  op_a,
    input  logic [EXP_W+FRAC_W:0]  op_b,
    input  logic [2:0]             rule_sel,
    input  logic                   dflt_nan_mode,
    output logic                   out_valid,
    output logic [EXP_W+FRAC_W:0]  result,
    output logic                   is_nan_result,
    output logic                   invalid_flag,
    output logic                   rule_error
);
    localparam int W = EXP_W + FRAC_W + 1;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] QUIET_MASK = W'(1) << (FRAC_W - 1);

    nan_kind_e  kinds [2];
    logic [W-1:0] ops [2];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // One classifier per operand.
    for (genvar g = 0; g < 2; g++) begin : g_cls
        nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .operand (ops[g]),
            .kind    (kinds[g])
        );
    end

    logic pick_b;
    logic policy_bad;

    nan_pick #(.FRAC_W(FRAC_W)) u_pick (
        .kind_a     (kinds[0]),
        .kind_b     (kinds[1]),
        .sign_a     (op_a[W-1]),
        .sign_b     (op_b[W-1]),
        .frac_a     (op_a[FRAC_W-1:0]),
        .frac_b     (op_b[FRAC_W-1:0]),
        .policy     (rule_sel),
        .pick_b     (pick_b),
        .policy_bad (policy_bad)
    );

    logic         any_nan;
    logic         any_snan;
    logic         err_d;
    logic [W-1:0] res_d;

    // Combine the pick with mode and error handling, and quiet the result.
    always_comb begin
        any_nan  = (kinds[0] != KIND_NUM) || (kinds[1] != KIND_NUM);
        any_snan = (kinds[0] == KIND_SNAN) || (kinds[1] == KIND_SNAN);
        err_d    = any_nan && !dflt_nan_mode && policy_bad;
        if (!any_nan)
            res_d = '0;
        else if (dflt_nan_mode || policy_bad)
            res_d = CANON_NAN;
        else
            res_d = (pick_b ? op_b : op_a) | QUIET_MASK;
    end

    // Output register: load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            result        <= '0;
            is_nan_result <= 1'b0;
            invalid_flag  <= 1'b0;
            rule_error    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result        <= res_d;
                is_nan_result <= any_nan;
                invalid_flag  <= any_snan;
                rule_error    <= err_d;
            end
        end
    end
endmodule

// File: rtl/nan_prop_sel_chk.sv
// Module: nan_prop_sel_chk
// Port-level properties of the NaN selector, bound to the top.
module nan_prop_sel_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [2:0]            rule_sel,
    input logic                  dflt_nan_mode,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  is_nan_result,
    input logic                  invalid_flag,
    input logic                  rule_error
);
    localparam int W = EXP_W + FRAC_W + 1;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(rule_error)
                       && $stable(invalid_flag) && $stable(is_nan_result)));
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_nan_result |-> result[FRAC_W-1]);
    p_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nan_result |-> (!invalid_flag && !rule_error && result == '0));
    p_err_canon_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rule_error |-> (is_nan_result && result == CANON_NAN));
    p_dflt_noerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dflt_nan_mode) |=> !rule_error);
    p_rule_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rule_sel != 3'd0 && rule_sel < 3'd6) |=> !rule_error);
endmodule

bind nan_prop_sel nan_prop_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .rule_sel      (rule_sel),
    .dflt_nan_mode (dflt_nan_mode),
    .out_valid     (out_valid),
    .result        (result),
    .is_nan_result (is_nan_result),
    .invalid_flag  (invalid_flag),
    .rule_error    (rule_error)
);

// File: tb/nan_prop_sel_tb.sv
module nan_prop_sel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  rule_sel = '0;
    logic        dflt_nan_mode = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        is_nan_result;
    logic        invalid_flag;
    logic        rule_error;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    nan_prop_sel u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .rule_sel(rule_sel),
        .dflt_nan_mode(dflt_nan_mode), .out_valid(out_valid),
        .result(result), .is_nan_result(is_nan_result),
        .invalid_flag(invalid_flag), .rule_error(rule_error)
    );

    logic [31:0] vals [9];
    initial begin
        vals[0] = 32'h3F800000; vals[1] = 32'h7F800000; vals[2] = 32'hC0000000;
        vals[3] = 32'h7FC00001; vals[4] = 32'hFFC00005; vals[5] = 32'h7FC00005;
        vals[6] = 32'h7F800003; vals[7] = 32'hFF800003; vals[8] = 32'h7F800001;
    end

    // kind: 0 number, 1 quiet, 2 signaling
    function automatic int kind_of(input logic [31:0] v);
        if (v[30:23] != 8'hFF || v[22:0] == 0) return 0;
        return v[22] ? 1 : 2;
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [31:0] a, input logic [31:0] b,
                           input int rule, input logic dm);
        int ka, kb;
        bit nan, snan, err, selb;
        logic [31:0] exp_res;
        string tag;
        ka = kind_of(a); kb = kind_of(b);
        nan = (ka != 0) || (kb != 0);
        snan = (ka == 2) || (kb == 2);
        err = nan && !dm && (rule == 0 || rule > 5);
        selb = 0;
        tag = "R1";
        case (rule)
            1: begin tag = "R2"; selb = (ka == 2) ? 0 : (kb == 2) ? 1 : (ka == 1) ? 0 : 1; end
            2: begin tag = "R3"; selb = (kb == 2) ? 1 : (ka == 2) ? 0 : (kb == 1) ? 1 : 0; end
            3: begin tag = "R4"; selb = (ka == 0); end
            4: begin tag = "R4"; selb = (kb != 0); end
            5: begin
                tag = "R5";
                if (ka == 0) selb = 1;
                else if (kb == 0) selb = 0;
                else if (ka != kb) selb = (kb == 1);
                else begin
                    tag = "R6";
                    if (a[22:0] != b[22:0]) selb = b[22:0] > a[22:0];
                    else selb = a[31] && !b[31];
                end
            end
            default: ;
        endcase
        if (!nan) begin exp_res = 32'h0; tag = "R1"; end
        else if (dm) begin exp_res = 32'h7FC00000; tag = "R8"; end
        else if (err) begin exp_res = 32'h7FC00000; tag = "R9"; end
        else exp_res = (selb ? b : a) | 32'h00400000;

        @(negedge clk);
        op_a = a; op_b = b; rule_sel = 3'(rule); dflt_nan_mode = dm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, result, exp_res);
        check("R1 is_nan_result", {31'b0, is_nan_result}, {31'b0, nan});
        check("R10 invalid_flag", {31'b0, invalid_flag}, {31'b0, snan});
        check(err ? "R9 rule_error" : "R8 rule_error", {31'b0, rule_error}, {31'b0, err});
        if (nan) check("R7 quiet bit", {31'b0, result[22]}, 32'd1);
        check("R11 out_valid", {31'b0, out_valid}, 32'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL R11 watchdog actual=%0d expected<150000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset out_valid", {31'b0, out_valid}, 32'd0);
        check("R11 reset result", result, 32'd0);
        check("R11 reset flags", {29'b0, is_nan_result, invalid_flag, rule_error}, 32'd0);
        rst_n = 1'b1;

        // R6 directed tie: equal fractions, A negative, B positive -> B
        run_vec(32'hFFC00005, 32'h7FC00005, 5, 1'b0);
        check("R6 sign tie", result, 32'h7FC00005);
        // R6 equal fraction and sign -> A; signaling pair quieted
        run_vec(32'h7F800003, 32'h7F800003, 5, 1'b0);
        check("R6 full tie", result, 32'h7FC00003);

        // R11 hold: no strobe, inputs change, outputs stay
        @(negedge clk);
        op_a = 32'h7F800001; op_b = 32'h3F800000; rule_sel = 3'd0;
        @(negedge clk);
        check("R11 hold result", result, 32'h7FC00003);
        check("R11 idle out_valid", {31'b0, out_valid}, 32'd0);

        for (int r = 0; r < 8; r++)
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < 9; i++)
                    for (int j = 0; j < 9; j++)
                        run_vec(vals[i], vals[j], r, d[0]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule